// File: doc/BRIEF.md
# LED Driver Fault Supervisor

This block is the digital fault supervisor of a boost-type LED string driver. It watches the outputs of the analog protection comparators (output over-voltage, switch-node over-voltage, per-cycle switch current limit, compensation-node overcurrent, die over-temperature, per-string short detect, supply undervoltage) together with the soft-start timeout flag. For each fault it decides whether to hold the converter off until a deliberate clear, or to recover by itself.

A mode input chooses between the two policies for the faults that have a choice. Two faults latch whatever the mode. The per-cycle current limit only blanks the switch for the rest of the cycle. In auto-recovery mode an output over-voltage does not stop the converter. It drops from regulation every active string that is below its regulation point.

The outputs go to the converter sequencer: a shutdown request, a one-cycle request to re-enter soft start, a per-string disable mask, the cycle blanking signal, and an active-low fault flag. Every input passes through a two-flop synchroniser. All results are registered, so each one appears on the third rising clock edge after its cause.

Top module: `ledFaultSupervisor`

## Requirements
- R1: While rstN is low: shutdownReq=1, faultN=1, restartReq=0, switchOff=0 and chanDisable=0.
- R2: Every output responds on the third rising edge after an input change (two synchroniser stages plus one output register). It has not responded after the second edge.
- R3: With modeAuto=0, an output over-voltage, compensation overcurrent, over-temperature or soft-start timeout latches the block. shutdownReq=1 and faultN=0 persist after the comparator returns low.
- R4: A switch-node over-voltage and a string short latch for both values of modeAuto.
- R5: A string short counts only when the same bit is set in activeMask. The latch sets exactly when (shortCmp & activeMask) is non-zero.
- R6: ilimCmp drives switchOff with the latency of R2. It never changes shutdownReq or faultN and never latches.
- R7: A latch clears only while enableIn is low or uvloCmp is high. While either holds, no latch can set, even if its fault is present.
- R8: uvloCmp high forces shutdownReq=1 and faultN=0. When it falls the block runs again with no latch and no restart pulse.
- R9: With modeAuto=1, ovpCmp high ORs (belowReg & activeMask) into chanDisable without a shutdown, and faultN=0 while ovpCmp is high. Bits stay set until the clear of R7.
- R10: With modeAuto=1, compensation overcurrent or soft-start timeout holds shutdownReq=1 and faultN=0 while high. When the last such fault ends, restartReq is high for exactly one cycle.
- R11: With modeAuto=1, over-temperature holds the shutdown until tempOk=1 with otCmp=0, and is then followed by the one-cycle restart pulse.
- R12: restartReq never pulses while enableIn is low, uvloCmp is high or any latch is set, and shutdownReq=1 whenever enableIn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enableIn | input | 1 | Device enable; low clears latches |
| modeAuto | input | 1 | 1 = auto-recovery, 0 = latch for selectable faults |
| ovpCmp | input | 1 | Output over-voltage comparator |
| diodeCmp | input | 1 | Switch-node over-voltage comparator |
| ilimCmp | input | 1 | Per-cycle switch current limit |
| ocCmp | input | 1 | Compensation-node overcurrent comparator |
| otCmp | input | 1 | Over-temperature flag |
| tempOk | input | 1 | Die cooled below recovery threshold |
| uvloCmp | input | 1 | Supply undervoltage |
| ssTimeout | input | 1 | Soft-start timeout flag |
| shortCmp | input | CHANNELS | Per-string short detect |
| belowReg | input | CHANNELS | Per-string below-regulation flag |
| activeMask | input | CHANNELS | Strings in use |
| shutdownReq | output | 1 | Converter off request |
| restartReq | output | 1 | One-cycle soft-start re-entry request |
| chanDisable | output | CHANNELS | Strings removed from regulation |
| switchOff | output | 1 | Blank switch for rest of cycle |
| faultN | output | 1 | Active-low fault flag (1 = released) |

## Verification
Each result is due on the third rising edge after its stimulus. The bench drives inputs on falling edges, waits three rising edges and samples on the next falling edge. It also checks that switchOff has not responded after only two edges. The restart pulse is sampled in the cycle it is due and again one cycle later, to confirm that it lasts one cycle. Short detection and the over-voltage trim are swept over all 64 string patterns, and the expected mask is computed as a bitwise AND in the bench.

// File: rtl/ledFaultPkg.sv
package ledFaultPkg;

  // Commands from the control to the datapath latch/mask registers
  typedef struct packed {
    logic clearAll;
    logic setOvp;
    logic setOc;
    logic setOt;
    logic setSs;
    logic setDiode;
    logic setShort;
    logic trimMask;
  } latchCmd_t;

  localparam int LATCH_KINDS = 6;
  localparam int L_OVP   = 0;
  localparam int L_OC    = 1;
  localparam int L_OT    = 2;
  localparam int L_SS    = 3;
  localparam int L_DIODE = 4;
  localparam int L_SHORT = 5;

endpackage

// File: rtl/ledFaultSync.sv
module ledFaultSync #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [DEPTH-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage <= '0;
    end else begin
      stage[0] <= d;
      for (int s = 1; s < DEPTH; s++) stage[s] <= stage[s-1];
    end
  end

  assign q = stage[DEPTH-1];
endmodule

// File: rtl/ledFaultDatapath.sv
module ledFaultDatapath
  import ledFaultPkg::*;
#(
  parameter int CHANNELS   = 6,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enableIn,
  input  logic                modeAuto,
  input  logic                ovpCmp,
  input  logic                diodeCmp,
  input  logic                ilimCmp,
  input  logic                ocCmp,
  input  logic                otCmp,
  input  logic                tempOk,
  input  logic                uvloCmp,
  input  logic                ssTimeout,
  input  logic [CHANNELS-1:0] shortCmp,
  input  logic [CHANNELS-1:0] belowReg,
  input  logic [CHANNELS-1:0] activeMask,
  input  latchCmd_t           cmd,
  output logic                enS,
  output logic                modeS,
  output logic                ovpS,
  output logic                diodeS,
  output logic                ocS,
  output logic                otS,
  output logic                tempOkS,
  output logic                uvloS,
  output logic                ssS,
  output logic                shortHit,
  output logic                latchNextAny,
  output logic [CHANNELS-1:0] chanDisable,
  output logic                switchOff
);
  localparam int SCALARS  = 10;
  localparam int SYNC_W   = SCALARS + 3 * CHANNELS;
  localparam int OFS_ACT  = SCALARS;
  localparam int OFS_BEL  = SCALARS + CHANNELS;
  localparam int OFS_SHT  = SCALARS + 2 * CHANNELS;

  logic [SYNC_W-1:0]      rawBus;
  logic [SYNC_W-1:0]      syncBus;
  logic                   ilimS;
  logic [CHANNELS-1:0]    activeS;
  logic [CHANNELS-1:0]    belowS;
  logic [CHANNELS-1:0]    shortS;
  logic [LATCH_KINDS-1:0] latchQ;
  logic [LATCH_KINDS-1:0] latchNext;
  logic [LATCH_KINDS-1:0] setVec;
  logic [CHANNELS-1:0]    trimNext;

  assign rawBus = {shortCmp, belowReg, activeMask, ssTimeout, uvloCmp, tempOk,
                   otCmp, ocCmp, ilimCmp, diodeCmp, ovpCmp, modeAuto, enableIn};

  ledFaultSync #(.WIDTH(SYNC_W), .DEPTH(SYNC_DEPTH)) sync_i (
    .clk (clk),
    .rstN(rstN),
    .d   (rawBus),
    .q   (syncBus)
  );

  assign enS     = syncBus[0];
  assign modeS   = syncBus[1];
  assign ovpS    = syncBus[2];
  assign diodeS  = syncBus[3];
  assign ilimS   = syncBus[4];
  assign ocS     = syncBus[5];
  assign otS     = syncBus[6];
  assign tempOkS = syncBus[7];
  assign uvloS   = syncBus[8];
  assign ssS     = syncBus[9];
  assign activeS = syncBus[OFS_ACT +: CHANNELS];
  assign belowS  = syncBus[OFS_BEL +: CHANNELS];
  assign shortS  = syncBus[OFS_SHT +: CHANNELS];

  // Short detect only on strings in use
  assign shortHit = |(shortS & activeS);

  always_comb begin
    setVec          = '0;
    setVec[L_OVP]   = cmd.setOvp;
    setVec[L_OC]    = cmd.setOc;
    setVec[L_OT]    = cmd.setOt;
    setVec[L_SS]    = cmd.setSs;
    setVec[L_DIODE] = cmd.setDiode;
    setVec[L_SHORT] = cmd.setShort;
  end

  // Clear has priority over set
  always_comb begin
    latchNext = cmd.clearAll ? '0 : (latchQ | setVec);
    trimNext  = cmd.clearAll ? '0
              : (chanDisable | (cmd.trimMask ? (belowS & activeS) : '0));
  end

  assign latchNextAny = |latchNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ      <= '0;
      chanDisable <= '0;
      switchOff   <= 1'b0;
    end else begin
      latchQ      <= latchNext;
      chanDisable <= trimNext;
      switchOff   <= ilimS;
    end
  end

  generate
    for (genvar k = 0; k < LATCH_KINDS; k++) begin : g_hold
      // R7
      latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        (latchQ[k] && !cmd.clearAll) |=> latchQ[k]);
    end
  endgenerate

  // R9
  mask_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.clearAll |=> ((chanDisable & $past(chanDisable)) == $past(chanDisable)));

endmodule

// File: rtl/ledFaultCtrl.sv
module ledFaultCtrl
  import ledFaultPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enS,
  input  logic      modeS,
  input  logic      ovpS,
  input  logic      diodeS,
  input  logic      ocS,
  input  logic      otS,
  input  logic      tempOkS,
  input  logic      uvloS,
  input  logic      ssS,
  input  logic      shortHit,
  input  logic      latchNextAny,
  output latchCmd_t cmd,
  output logic      shutdownReq,
  output logic      restartReq,
  output logic      faultN
);
  logic otHoldQ;
  logic otHoldNext;
  logic autoQ;
  logic autoNext;

  always_comb begin
    cmd.clearAll = !enS || uvloS;
    cmd.setOvp   = ovpS && !modeS;
    cmd.setOc    = ocS  && !modeS;
    cmd.setOt    = otS  && !modeS;
    cmd.setSs    = ssS  && !modeS;
    cmd.setDiode = diodeS;
    cmd.setShort = shortHit;
    cmd.trimMask = ovpS && modeS;
  end

  // Over-temperature hold releases only once cooled and comparator low
  assign otHoldNext = (otS && modeS) || (otHoldQ && !tempOkS);
  assign autoNext   = (ocS && modeS) || (ssS && modeS) || otHoldNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      otHoldQ     <= 1'b0;
      autoQ       <= 1'b0;
      shutdownReq <= 1'b1;
      restartReq  <= 1'b0;
      faultN      <= 1'b1;
    end else begin
      otHoldQ     <= otHoldNext;
      autoQ       <= autoNext;
      shutdownReq <= latchNextAny || uvloS || !enS || autoNext;
      restartReq  <= autoQ && !autoNext && enS && !uvloS && !latchNextAny;
      faultN      <= !(latchNextAny || uvloS || autoNext || ovpS);
    end
  end

  // R3
  latch_shut_chk: assert property (@(posedge clk) disable iff (!rstN)
    latchNextAny |=> shutdownReq);

  // R8
  uvlo_shut_chk: assert property (@(posedge clk) disable iff (!rstN)
    uvloS |=> (shutdownReq && !faultN));

  // R10
  restart_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    restartReq |=> !restartReq);

  // R12
  restart_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    restartReq |-> !shutdownReq);

endmodule

// File: rtl/ledFaultSupervisor.sv
module ledFaultSupervisor
  import ledFaultPkg::*;
#(
  parameter int CHANNELS   = 6,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enableIn,
  input  logic                modeAuto,
  input  logic                ovpCmp,
  input  logic                diodeCmp,
  input  logic                ilimCmp,
  input  logic                ocCmp,
  input  logic                otCmp,
  input  logic                tempOk,
  input  logic                uvloCmp,
  input  logic                ssTimeout,
  input  logic [CHANNELS-1:0] shortCmp,
  input  logic [CHANNELS-1:0] belowReg,
  input  logic [CHANNELS-1:0] activeMask,
  output logic                shutdownReq,
  output logic                restartReq,
  output logic [CHANNELS-1:0] chanDisable,
  output logic                switchOff,
  output logic                faultN
);
  latchCmd_t cmd;
  logic enS, modeS, ovpS, diodeS, ocS, otS, tempOkS, uvloS, ssS;
  logic shortHit, latchNextAny;

  ledFaultDatapath #(.CHANNELS(CHANNELS), .SYNC_DEPTH(SYNC_DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .enableIn(enableIn), .modeAuto(modeAuto),
    .ovpCmp(ovpCmp), .diodeCmp(diodeCmp), .ilimCmp(ilimCmp), .ocCmp(ocCmp),
    .otCmp(otCmp), .tempOk(tempOk), .uvloCmp(uvloCmp), .ssTimeout(ssTimeout),
    .shortCmp(shortCmp), .belowReg(belowReg), .activeMask(activeMask),
    .cmd(cmd), .enS(enS), .modeS(modeS), .ovpS(ovpS), .diodeS(diodeS),
    .ocS(ocS), .otS(otS), .tempOkS(tempOkS), .uvloS(uvloS), .ssS(ssS),
    .shortHit(shortHit), .latchNextAny(latchNextAny),
    .chanDisable(chanDisable), .switchOff(switchOff)
  );

  ledFaultCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .enS(enS), .modeS(modeS), .ovpS(ovpS),
    .diodeS(diodeS), .ocS(ocS), .otS(otS), .tempOkS(tempOkS), .uvloS(uvloS),
    .ssS(ssS), .shortHit(shortHit), .latchNextAny(latchNextAny), .cmd(cmd),
    .shutdownReq(shutdownReq), .restartReq(restartReq), .faultN(faultN)
  );
endmodule

// File: tb/ledFaultSupervisor_tb_top.sv
module ledFaultSupervisor_tb_top;
  localparam int NCH = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enableIn = 0, modeAuto = 0, ovpCmp = 0, diodeCmp = 0, ilimCmp = 0;
  logic ocCmp = 0, otCmp = 0, tempOk = 1, uvloCmp = 0, ssTimeout = 0;
  logic [NCH-1:0] shortCmp = '0, belowReg = '0, activeMask = '1;
  logic shutdownReq, restartReq, switchOff, faultN;
  logic [NCH-1:0] chanDisable;

  int vectors = 0;
  int miscompares = 0;

  always #4 clk = ~clk;

  ledFaultSupervisor #(.CHANNELS(NCH)) dut_i (
    .clk(clk), .rstN(rstN), .enableIn(enableIn), .modeAuto(modeAuto),
    .ovpCmp(ovpCmp), .diodeCmp(diodeCmp), .ilimCmp(ilimCmp), .ocCmp(ocCmp),
    .otCmp(otCmp), .tempOk(tempOk), .uvloCmp(uvloCmp), .ssTimeout(ssTimeout),
    .shortCmp(shortCmp), .belowReg(belowReg), .activeMask(activeMask),
    .shutdownReq(shutdownReq), .restartReq(restartReq),
    .chanDisable(chanDisable), .switchOff(switchOff), .faultN(faultN)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clearLatches();
    enableIn = 1'b0;
    settle();
    enableIn = 1'b1;
    settle();
  endtask

  task automatic setKind(input int k, input logic v);
    case (k)
      0: ovpCmp = v;
      1: ocCmp = v;
      2: otCmp = v;
      default: ssTimeout = v;
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired");
    miscompares++;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 shutdownReq", 32'(shutdownReq), 1);
    chk("R1 faultN", 32'(faultN), 1);
    chk("R1 restartReq", 32'(restartReq), 0);
    chk("R1 switchOff", 32'(switchOff), 0);
    chk("R1 chanDisable", 32'(chanDisable), 0);
    rstN = 1'b1;
    @(negedge clk);
    enableIn = 1'b1;
    settle();
    chk("R12 run after enable", 32'(shutdownReq), 0);

    // R2 latency and R6 current limit
    ilimCmp = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R2 switchOff after two edges", 32'(switchOff), 0);
    @(negedge clk);
    chk("R2 switchOff after three edges", 32'(switchOff), 1);
    chk("R6 no shutdown", 32'(shutdownReq), 0);
    chk("R6 faultN released", 32'(faultN), 1);
    ilimCmp = 1'b0;
    settle();
    chk("R6 switchOff follows", 32'(switchOff), 0);

    // R3 latched mode for selectable faults, R7 clear by enable
    modeAuto = 1'b0;
    for (int k = 0; k < 4; k++) begin
      setKind(k, 1'b1);
      settle();
      chk("R3 shutdown on fault", 32'(shutdownReq), 1);
      chk("R3 faultN low", 32'(faultN), 0);
      setKind(k, 1'b0);
      settle();
      chk("R3 shutdown held", 32'(shutdownReq), 1);
      chk("R3 faultN held", 32'(faultN), 0);
      chk("R3 chanDisable untouched", 32'(chanDisable), 0);
      clearLatches();
      chk("R7 cleared by enable", 32'(shutdownReq), 0);
      chk("R7 faultN released", 32'(faultN), 1);
    end

    // R4 always-latching faults in both modes
    for (int m = 0; m < 2; m++) begin
      modeAuto = logic'(m);
      diodeCmp = 1'b1;
      settle();
      diodeCmp = 1'b0;
      settle();
      chk("R4 diode latch", 32'({shutdownReq, faultN}), 32'b10);
      clearLatches();
      shortCmp = 6'b000100;
      settle();
      shortCmp = '0;
      settle();
      chk("R4 short latch", 32'({shutdownReq, faultN}), 32'b10);
      clearLatches();
    end

    // R5 short sweep against active mask
    modeAuto = 1'b1;
    for (int a = 0; a < 4; a++) begin
      logic [NCH-1:0] act;
      act = (a == 0) ? '1 : (a == 1) ? 6'b010101 : (a == 2) ? 6'b101010 : '0;
      activeMask = act;
      for (int s = 0; s < 64; s++) begin
        shortCmp = NCH'(s);
        settle();
        chk("R5 short gated by mask", 32'(shutdownReq), 32'(|(NCH'(s) & act)));
        shortCmp = '0;
        clearLatches();
      end
    end
    activeMask = '1;

    // R7 clear wins, R8 undervoltage
    enableIn = 1'b0;
    diodeCmp = 1'b1;
    settle();
    chk("R7 no latch while enable low", 32'(faultN), 1);
    chk("R12 shutdown while enable low", 32'(shutdownReq), 1);
    enableIn = 1'b1;
    settle();
    chk("R7 latch sets once enabled", 32'(faultN), 0);
    diodeCmp = 1'b0;
    uvloCmp = 1'b1;
    settle();
    chk("R8 uvlo shutdown", 32'({shutdownReq, faultN}), 32'b10);
    uvloCmp = 1'b0;
    settle();
    chk("R8 uvlo not latched", 32'({shutdownReq, faultN}), 32'b01);
    chk("R8 no restart after uvlo", 32'(restartReq), 0);

    // R9 auto-mode over-voltage trim sweep
    modeAuto = 1'b1;
    for (int b = 0; b < 64; b++) begin
      logic [NCH-1:0] act;
      act = b[0] ? '1 : 6'b101101;
      activeMask = act;
      belowReg = NCH'(b);
      ovpCmp = 1'b1;
      settle();
      chk("R9 trim mask", 32'(chanDisable), 32'(NCH'(b) & act));
      chk("R9 no shutdown", 32'(shutdownReq), 0);
      chk("R9 faultN during ovp", 32'(faultN), 0);
      ovpCmp = 1'b0;
      belowReg = '1;
      settle();
      chk("R9 trim sticky", 32'(chanDisable), 32'(NCH'(b) & act));
      chk("R9 faultN after ovp", 32'(faultN), 1);
      clearLatches();
      chk("R9 trim cleared", 32'(chanDisable), 0);
    end
    activeMask = '1;
    belowReg = '0;

    // R10 auto-mode overcurrent and timeout
    for (int k = 1; k < 4; k += 2) begin
      setKind(k, 1'b1);
      settle();
      chk("R10 hold shutdown", 32'({shutdownReq, faultN}), 32'b10);
      setKind(k, 1'b0);
      settle();
      chk("R10 restart pulse", 32'(restartReq), 1);
      @(negedge clk);
      chk("R10 pulse one cycle", 32'(restartReq), 0);
      chk("R10 running", 32'({shutdownReq, faultN}), 32'b01);
    end

    // R11 auto-mode over-temperature hysteresis
    tempOk = 1'b0;
    otCmp = 1'b1;
    settle();
    otCmp = 1'b0;
    settle();
    chk("R11 held until cooled", 32'({shutdownReq, restartReq}), 32'b10);
    tempOk = 1'b1;
    settle();
    chk("R11 restart pulse", 32'(restartReq), 1);
    @(negedge clk);
    chk("R11 running", 32'({shutdownReq, restartReq, faultN}), 32'b001);

    // R12 no restart while disabled
    ocCmp = 1'b1;
    settle();
    enableIn = 1'b0;
    settle();
    ocCmp = 1'b0;
    settle();
    chk("R12 no restart when disabled", 32'(restartReq), 0);
    @(negedge clk);
    chk("R12 still no restart", 32'(restartReq), 0);
    enableIn = 1'b1;
    settle();
    chk("R12 run after re-enable", 32'({shutdownReq, restartReq}), 0);

    // R12 no restart while a latch is set
    diodeCmp = 1'b1;
    ocCmp = 1'b1;
    settle();
    diodeCmp = 1'b0;
    ocCmp = 1'b0;
    settle();
    chk("R12 no restart with latch", 32'(restartReq), 0);
    clearLatches();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule